// File: doc/BRIEF.md
# Reciprocal Frequency Counter Gate

This block watches one asynchronous digital input and measures it over whole input periods. A boundary is a rising edge of the synchronized input. The first boundary after reset opens a measurement. From then on, a repeating gate timer sets a minimum window length from the `gate_len` input. Once that minimum has passed, the measurement closes on the next boundary. The same edge opens the next measurement, so consecutive windows join without a gap and no input cycle is lost.

While a window is open, an accumulator adds one of three quantities, chosen by `acc_sel`:
- every clock,
- every clock the synchronized input is high, or
- every input period.

A second counter always counts the clocks of the window. At the close, both values are copied to output registers together and a ready flag is raised.

A host can compute frequency from two windows of the same length. It multiplies the system clock rate by the period count and divides by the clock count. Duty cycle is the high-clock count over the clock count. The block does not perform either division.

Top module: `recip_gate_counter`

## Requirements
- R1: During and right after reset, `result`, `elapsed` and `ready` are 0.
- R2: The input passes through a two-flop synchronizer. A boundary is a clock in which the synchronized level is 1 and was 0 one clock earlier. Nothing accumulates and nothing is captured before the first boundary, which opens the first window.
- R3: A window closes only on a boundary. The close happens once at least max(X,1) clocks have passed since the window opened, where X is the `gate_len` value sampled on the opening clock.
- R4: The closing boundary opens the next window in the same clock. The new accumulator starts at that clock's increment, so a steady input of period P, with X no greater than P, gives P in every time-mode result.
- R5: With `acc_sel` = 2'b00 (time), the result counts clocks from the opening boundary up to the clock before the closing boundary.
- R6: With `acc_sel` = 2'b01 (high), the result counts the clocks of the window in which the synchronized input is 1.
- R7: With `acc_sel` = 2'b10 or 2'b11 (periods), the result counts the boundaries in the window. The opening boundary is included and the closing boundary is not.
- R8: `elapsed` gives the clock count of the same window. Every captured result satisfies 1 <= `result` <= `elapsed`.
- R9: `ready` is set in the clock after a capture. It is cleared by `rd_ack` when no capture happens in that clock. A capture wins over a simultaneous `rd_ack`.
- R10: If no boundary arrives, the window stays open. Both counters stop at all ones and do not wrap, so the eventual capture reports 2^CNT_W-1.
- R11: `result` and `elapsed` change only on a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Asynchronous input being measured |
| gate_len | input | GATE_W | Minimum window length X in clocks |
| acc_sel | input | 2 | Accumulate selection: 00 time, 01 high, 1x periods |
| rd_ack | input | 1 | Host read strobe; clears `ready` |
| result | output | CNT_W | Accumulated value of the last closed window |
| elapsed | output | CNT_W | Clock count of the last closed window |
| ready | output | 1 | A new capture is waiting |

## Verification
The bound checker covers four properties on every cycle:
- a capture happens only on a boundary and only after the gate has expired;
- `ready` follows capture and read in the right priority;
- the outputs hold between captures;
- any reported result is nonzero and no larger than the elapsed count.

The bench drives several scenarios and compares every clock against a behavioural model. Only those scenarios can show the exact window lengths and the per-mode counts. They also show the joined windows at a steady period, the zero-length gate and the saturation after a long quiet input.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
   typedef enum logic [1:0] {
      ACC_TIME    = 2'b00,
      ACC_HIGH    = 2'b01,
      ACC_PERIOD  = 2'b10,
      ACC_PERIOD2 = 2'b11
   } acc_mode_e;
endpackage

// File: rtl/rgc_edge_sync.sv
// Synchronizer chain plus rising-edge detector on the synchronized level.
module rgc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rgc_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level = chain_q[STAGES-1];
   assign rise  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/rgc_gate_timer.sv
// Minimum-gate down counter: loads on each window start, stops at 1.
module rgc_gate_timer #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] len,
   output logic         expired
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (load) begin
         left_q <= len;
      end else if (left_q > ONE) begin
         left_q <= left_q - ONE;
      end
   end

   assign expired = (left_q <= ONE);
endmodule

// File: rtl/rgc_sat_counter.sv
// Seedable counter; SATURATE picks a stop-at-all-ones or a wrapping variant.
module rgc_sat_counter #(
   parameter int W        = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         seed,
   input  logic         step,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W-1:0] next_w;

   if (SATURATE) begin : g_sat
      assign next_w = (count == TOP) ? count : count + W'(1);
   end else begin : g_wrap
      assign next_w = count + W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (seed) begin
         count <= {{(W-1){1'b0}}, step};
      end else if (step) begin
         count <= next_w;
      end
   end
endmodule

// File: rtl/recip_gate_counter.sv
module recip_gate_counter
   import rgc_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int GATE_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sig_in,
   input  logic [GATE_W-1:0] gate_len,
   input  logic [1:0]        acc_sel,
   input  logic              rd_ack,
   output logic [CNT_W-1:0]  result,
   output logic [CNT_W-1:0]  elapsed,
   output logic              ready
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("recip_gate_counter: CNT_W must be at least 2");
   end
   if (GATE_W < 1) begin : g_bad_gate
      $error("recip_gate_counter: GATE_W must be at least 1");
   end

   logic lvl_w, rise_w, gate_expired;
   logic run_q, open_w, cap_w, seed_w, inc_w, live_w;
   logic [CNT_W-1:0] acc_w, clk_cnt_w;

   rgc_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(sig_in),
      .level   (lvl_w),
      .rise    (rise_w)
   );

   assign open_w = ~run_q & rise_w;
   assign cap_w  = run_q & gate_expired & rise_w;
   assign seed_w = open_w | cap_w;
   assign live_w = run_q | open_w;

   always_comb begin
      unique case (acc_mode_e'(acc_sel))
         ACC_TIME: inc_w = 1'b1;
         ACC_HIGH: inc_w = lvl_w;
         default:  inc_w = rise_w;
      endcase
   end

   rgc_gate_timer #(.W(GATE_W)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (seed_w),
      .len    (gate_len),
      .expired(gate_expired)
   );

   rgc_sat_counter #(.W(CNT_W), .SATURATE(SATURATE)) u_acc (
      .clk  (clk),
      .rst_n(rst_n),
      .seed (seed_w),
      .step (inc_w & live_w),
      .count(acc_w)
   );

   rgc_sat_counter #(.W(CNT_W), .SATURATE(SATURATE)) u_clks (
      .clk  (clk),
      .rst_n(rst_n),
      .seed (seed_w),
      .step (live_w),
      .count(clk_cnt_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         result  <= '0;
         elapsed <= '0;
         ready   <= 1'b0;
      end else begin
         if (open_w) begin
            run_q <= 1'b1;
         end
         if (cap_w) begin
            result  <= acc_w;
            elapsed <= clk_cnt_w;
            ready   <= 1'b1;
         end else if (rd_ack) begin
            ready   <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/recip_gate_counter_chk.sv
module recip_gate_counter_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_ack,
   input logic             rise,
   input logic             cap,
   input logic             expired,
   input logic             ready,
   input logic [CNT_W-1:0] result,
   input logic [CNT_W-1:0] elapsed
);
   p_cap_after_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cap |-> expired);

   p_cap_on_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cap |-> rise);

   p_result_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (result != '0));

   p_result_le_elapsed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (result <= elapsed));

   p_ready_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> ready);

   p_ready_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ack && !cap) |=> !ready);

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> ($stable(result) && $stable(elapsed)));
endmodule

bind recip_gate_counter recip_gate_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .rd_ack (rd_ack),
   .rise   (rise_w),
   .cap    (cap_w),
   .expired(gate_expired),
   .ready  (ready),
   .result (result),
   .elapsed(elapsed)
);

// File: tb/recip_gate_counter_tb_top.sv
module recip_gate_counter_tb_top;
   localparam int CW   = 10;
   localparam int GW   = 12;
   localparam int SATV = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sig_in = 1'b0;
   logic [GW-1:0] gate_len = '0;
   logic [1:0]    acc_sel = 2'b00;
   logic          rd_ack = 1'b0;
   logic [CW-1:0] result, elapsed;
   logic          ready;

   always #2 clk = ~clk;

   recip_gate_counter #(.CNT_W(CW), .GATE_W(GW)) dut_i (
      .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .gate_len(gate_len),
      .acc_sel(acc_sel), .rd_ack(rd_ack), .result(result),
      .elapsed(elapsed), .ready(ready)
   );

   int errs = 0, checks = 0, sat_seen = 0, exp_per = 0;
   bit done = 1'b0;
   // behavioural model state
   int  m_run, m_tim, m_acc, m_tc, m_res, m_el, m_rdy, m_xl;
   bit  m_cap;
   bit  h0, h1, h2, h3;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int sat_inc(input int v, input int d);
      return (v + d > SATV) ? SATV : v + d;
   endfunction

   task automatic model_edge(input bit ack);
      bit lvl, rz;
      int inc;
      lvl = h2;
      rz  = h2 && !h3;
      inc = (acc_sel == 2'b00) ? 1 : (acc_sel == 2'b01) ? int'(lvl) : int'(rz);
      m_cap = (m_run != 0) && (m_tim <= 1) && rz;
      if (m_cap) m_rdy = 1;
      else if (ack) m_rdy = 0;
      if (m_cap || (m_run == 0 && rz)) begin
         if (m_cap) begin
            m_res = m_acc;
            m_el  = m_tc;
         end
         m_acc = inc;
         m_tc  = 1;
         m_tim = int'(gate_len);
         m_run = 1;
      end else if (m_run != 0) begin
         m_acc = sat_inc(m_acc, inc);
         m_tc  = sat_inc(m_tc, 1);
         if (m_tim > 1) m_tim = m_tim - 1;
      end
   endtask

   task automatic step(input bit d, input bit ack);
      string rtag;
      int xl_prev;
      sig_in = d;
      rd_ack = ack;
      h3 = h2; h2 = h1; h1 = h0; h0 = d;
      xl_prev = m_xl;
      @(posedge clk);
      model_edge(ack);
      if (m_cap || m_xl == 0) m_xl = (int'(gate_len) < 1) ? 1 : int'(gate_len);
      @(negedge clk);
      rtag = (acc_sel == 2'b00) ? "R5 result" : (acc_sel == 2'b01) ? "R6 result" : "R7 result";
      chk(int'(result) == m_res, rtag, result, m_res);
      chk(int'(elapsed) == m_el, "R8 elapsed", elapsed, m_el);
      chk(int'(ready) == m_rdy, "R9 ready", ready, m_rdy);
      if (m_cap) begin
         chk(result >= 1 && result <= elapsed, "R8 bounds", result, elapsed);
         chk(int'(elapsed) >= xl_prev, "R3 min gate", elapsed, xl_prev);
         if (exp_per != 0) chk(int'(result) == exp_per, "R4 joined windows", result, exp_per);
         if (m_el == SATV) begin
            sat_seen++;
            chk(int'(elapsed) == SATV, "R10 saturation", elapsed, SATV);
         end
      end else begin
         chk(int'(result) == m_res && int'(elapsed) == m_el, "R11 hold", result, m_res);
      end
   endtask

   // ack_mode: 0 never, 1 read when ready, 2 always
   task automatic wave(input int hi, input int lo, input int n, input int ack_mode);
      int ph = 0;
      for (int i = 0; i < n; i++) begin
         bit a;
         a = (ack_mode == 2) ? 1'b1 : (ack_mode == 1) ? (m_rdy != 0) : 1'b0;
         step(ph < hi, a);
         ph = (ph + 1 == hi + lo) ? 0 : ph + 1;
      end
   endtask

   initial begin
      m_run = 0; m_tim = 0; m_acc = 0; m_tc = 0; m_res = 0; m_el = 0; m_rdy = 0; m_xl = 0;
      h0 = 0; h1 = 0; h2 = 0; h3 = 0;
      repeat (5) @(negedge clk);
      chk(result == '0 && elapsed == '0 && ready == 1'b0, "R1 reset", result, 0);
      rst_n = 1'b1;
      // idle: nothing before the first boundary
      gate_len = 12'd5;
      for (int i = 0; i < 20; i++) step(1'b0, 1'b1);
      chk(ready == 1'b0 && result == '0 && elapsed == '0, "R2 idle", ready, 0);
      // joined windows: time mode, X=5, period 7
      acc_sel = 2'b00; exp_per = 7;
      wave(3, 4, 84, 1);
      exp_per = 0;
      // longer gate, host acks every clock (capture must win)
      gate_len = 12'd20;
      wave(3, 4, 100, 2);
      // high-time mode
      acc_sel = 2'b01; gate_len = 12'd30;
      wave(2, 5, 150, 1);
      // period mode, both encodings
      acc_sel = 2'b10; gate_len = 12'd40;
      wave(3, 4, 150, 1);
      acc_sel = 2'b11; gate_len = 12'd10;
      wave(1, 1, 60, 1);
      // zero gate in time mode
      acc_sel = 2'b00; gate_len = 12'd0;
      wave(1, 2, 60, 0);
      // long quiet input then edges: saturation
      gate_len = 12'd3;
      for (int i = 0; i < 1100; i++) step(1'b0, 1'b0);
      wave(2, 2, 24, 1);
      chk(sat_seen > 0, "R10 saturated capture seen", sat_seen, 1);
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #40000;
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule